// File: doc/BRIEF.md
# Multi-Track Loop Record and Playback Sequencer

This block runs the recording and looping playback of audio tracks that live in one shared sample memory. The memory is divided into a fixed number of equal regions, one per track. A word address is formed as the region base of the active track plus a running sample index. The index moves forward by one on every sample-rate tick while the block is recording or playing.

A recording starts on a record pulse, but only when the track-select vector has exactly one bit set. A second record pulse stops it. So does reaching the end of the region. In both cases the recording is committed: the track becomes valid and its stored length is the number of samples written. A cancel pulse drops the recording. The track keeps its earlier valid flag and length, so playback is still bounded by the old length even though some old samples in memory may already be overwritten.

Playback loops a valid, singly selected track. It issues one read per tick and wraps the index at the recorded length. Memory is a plain synchronous word interface. Converting samples to and from the microphone and speaker formats, mixing tracks and driving a display are handled elsewhere.

Top module: `loop_sequencer`

## Requirements
- R1: After reset the block is idle. `mem_we`, `mem_re`, `play_valid` and `rec_active` are 0, `led` is all zeros, and every track is empty, so a play request after reset issues no reads.
- R2: While recording or playing, `mem_addr` equals `trk_idx * REGION_LEN + index`. `trk_idx` is the bit position of the single set bit of `trk_sel` at the moment the operation started.
- R3: A record pulse in idle starts a recording only when exactly one bit of `trk_sel` is set. When zero bits or two or more bits are set, the block stays idle.
- R4: While recording, each cycle with `tick` high writes `pcm_in` at the current address (`mem_we` = 1), and the index then advances by one. The first write of a recording goes to index 0.
- R5: A record pulse during a recording ends it and commits its length, which is the number of samples written and replaces any earlier length. A committed length of 0 leaves the track empty.
- R6: The tick that writes index `REGION_LEN-1` ends the recording and commits a length of `REGION_LEN`.
- R7: A cancel pulse during a recording returns the block to idle and leaves the track's earlier valid flag and length unchanged.
- R8: A play request (`play_en` = 1) in idle starts playback only for a singly selected, valid track. While `play_en` stays high, each tick raises `mem_re` and `play_valid` for that cycle, and the index wraps to 0 after length−1. When `play_en` drops, the block returns to idle.
- R9: `led` is all zeros in idle. While recording it has its lower half lit and its upper half dark. While playing every bit is lit.
- R10: In a recording cycle, cancel takes precedence over a record pulse, and a record pulse takes precedence over `tick`. A cycle that carries cancel or a record pulse writes nothing. A record pulse during playback is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trk_sel | input | N_TRACKS | Track-select vector, one-hot when valid |
| rec_pulse | input | 1 | Record start/stop pulse |
| cancel_pulse | input | 1 | Cancel the active recording |
| play_en | input | 1 | Play request level |
| tick | input | 1 | Sample-rate tick |
| pcm_in | input | SAMPLE_W | Input sample |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | SAMPLE_W | Memory write data |
| mem_re | output | 1 | Memory read request |
| trk_idx | output | TRK_W | Active track index (3 bits by default) |
| play_valid | output | 1 | A playback sample is requested this cycle |
| rec_active | output | 1 | Recording in progress |
| led | output | LED_W | Status light pattern |

## Verification
If the sample index is wrong, the next write or read address at the ports is wrong, one tick later. If a track's stored valid flag or length is wrong, nothing shows until that track is played. Then a read request appears where none belongs, or the wrap to index 0 comes early or late, within one loop length. For that reason every recording in the bench is followed by playback runs that span more than one loop. Selection and precedence errors show at once as a wrong `rec_active` or a wrong `mem_we` in the same cycle.

// File: rtl/loop_pkg.sv
package loop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REC  = 2'd1,
        ST_PLAY = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       commit;
    } seq_ctl_t;
endpackage

// File: rtl/loop_trk_decode.sv
module loop_trk_decode #(
    parameter int N_TRACKS = 8,
    parameter int TRK_W    = 3
) (
    input  logic [N_TRACKS-1:0] sel,
    output logic                single,
    output logic [TRK_W-1:0]    idx
);
    int cnt;
    always_comb begin
        cnt = 0;
        idx = '0;
        for (int i = 0; i < N_TRACKS; i++) begin
            if (sel[i]) begin
                cnt = cnt + 1;
                idx = TRK_W'(i);
            end
        end
        single = (cnt == 1);
    end
endmodule

// File: rtl/loop_trk_table.sv
module loop_trk_table #(
    parameter int N_TRACKS = 8,
    parameter int TRK_W    = 3,
    parameter int IDX_W    = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [TRK_W-1:0] commit_trk,
    input  logic [IDX_W-1:0] commit_len,
    input  logic [TRK_W-1:0] rd_trk,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_len
);
    logic [N_TRACKS-1:0] vld_q;
    logic [IDX_W-1:0]    len_q [N_TRACKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < N_TRACKS; i++) len_q[i] <= '0;
        end else if (commit) begin
            vld_q[commit_trk] <= (commit_len != '0);
            len_q[commit_trk] <= commit_len;
        end
    end

    assign rd_valid = vld_q[rd_trk];
    assign rd_len   = len_q[rd_trk];

    // R7: without a commit the table keeps every flag
    a_r7_table_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(vld_q));
    // R8: a valid track never carries a zero length
    a_r8_valid_len: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_len != '0);
endmodule

// File: rtl/loop_addr_gen.sv
module loop_addr_gen #(
    parameter int TRK_W      = 3,
    parameter int IDX_W      = 19,
    parameter int ADDR_W     = 22,
    parameter int REGION_LEN = 480000
) (
    input  logic [TRK_W-1:0]  trk,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] REGION = ADDR_W'(REGION_LEN);
    assign addr = (ADDR_W'(trk) * REGION) + ADDR_W'(idx);
endmodule

// File: rtl/loop_sequencer.sv
module loop_sequencer
    import loop_pkg::*;
#(
    parameter int N_TRACKS   = 8,
    parameter int SAMPLE_W   = 16,
    parameter int REGION_LEN = 480000,
    parameter int LED_W      = 16,
    localparam int TRK_W     = $clog2(N_TRACKS),
    localparam int IDX_W     = $clog2(REGION_LEN + 1),
    localparam int ADDR_W    = $clog2(N_TRACKS * REGION_LEN)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_TRACKS-1:0] trk_sel,
    input  logic                rec_pulse,
    input  logic                cancel_pulse,
    input  logic                play_en,
    input  logic                tick,
    input  logic [SAMPLE_W-1:0] pcm_in,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [SAMPLE_W-1:0] mem_wdata,
    output logic                mem_re,
    output logic [TRK_W-1:0]    trk_idx,
    output logic                play_valid,
    output logic                rec_active,
    output logic [LED_W-1:0]    led
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REGION_LEN - 1);
    localparam logic [IDX_W-1:0] FULL_LEN = IDX_W'(REGION_LEN);
    localparam logic [LED_W-1:0] LED_HALF =
        {{(LED_W - LED_W/2){1'b0}}, {(LED_W/2){1'b1}}};

    seq_state_e       state_q;
    logic [TRK_W-1:0] trk_q;
    logic [IDX_W-1:0] idx_q;
    seq_ctl_t         ctl;
    logic [TRK_W-1:0] trk_d;
    logic [IDX_W-1:0] idx_d, idx_inc, commit_len;

    logic             sel_single;
    logic [TRK_W-1:0] sel_idx, rd_trk;
    logic             tbl_valid;
    logic [IDX_W-1:0] tbl_len;

    loop_trk_decode #(.N_TRACKS(N_TRACKS), .TRK_W(TRK_W)) u_dec (
        .sel(trk_sel), .single(sel_single), .idx(sel_idx)
    );

    assign rd_trk = (state_q == ST_IDLE) ? sel_idx : trk_q;

    loop_trk_table #(.N_TRACKS(N_TRACKS), .TRK_W(TRK_W), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst(rst), .commit(ctl.commit), .commit_trk(trk_q),
        .commit_len(commit_len), .rd_trk(rd_trk),
        .rd_valid(tbl_valid), .rd_len(tbl_len)
    );

    loop_addr_gen #(.TRK_W(TRK_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
                    .REGION_LEN(REGION_LEN)) u_addr (
        .trk(trk_q), .idx(idx_q), .addr(mem_addr)
    );

    assign idx_inc = idx_q + IDX_W'(1);

    always_comb begin
        ctl.st     = state_q;
        ctl.commit = 1'b0;
        commit_len = idx_q;
        trk_d      = trk_q;
        idx_d      = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rec_pulse && sel_single) begin
                    ctl.st = ST_REC;
                    trk_d  = sel_idx;
                    idx_d  = '0;
                end else if (play_en && sel_single && tbl_valid) begin
                    ctl.st = ST_PLAY;
                    trk_d  = sel_idx;
                    idx_d  = '0;
                end
            end
            ST_REC: begin
                if (cancel_pulse) begin
                    ctl.st = ST_IDLE;
                end else if (rec_pulse) begin
                    ctl.st     = ST_IDLE;
                    ctl.commit = 1'b1;
                end else if (tick) begin
                    if (idx_q == LAST_IDX) begin
                        ctl.st     = ST_IDLE;
                        ctl.commit = 1'b1;
                        commit_len = FULL_LEN;
                    end else begin
                        idx_d = idx_inc;
                    end
                end
            end
            ST_PLAY: begin
                if (!play_en) begin
                    ctl.st = ST_IDLE;
                end else if (tick) begin
                    idx_d = (idx_inc == tbl_len) ? '0 : idx_inc;
                end
            end
            default: ctl.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            trk_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= ctl.st;
            trk_q   <= trk_d;
            idx_q   <= idx_d;
        end
    end

    assign rec_active = (state_q == ST_REC);
    assign mem_we     = rec_active && tick && !cancel_pulse && !rec_pulse;
    assign mem_wdata  = pcm_in;
    assign mem_re     = (state_q == ST_PLAY) && play_en && tick;
    assign play_valid = mem_re;
    assign trk_idx    = trk_q;
    assign led        = (state_q == ST_PLAY) ? {LED_W{1'b1}} :
                        rec_active            ? LED_HALF : '0;

    // R4: a write that is not the last advances the index by one
    a_r4_idx_step: assert property (@(posedge clk) disable iff (rst)
        (mem_we && idx_q != LAST_IDX) |=> idx_q == $past(idx_inc));
    // R6: the index never leaves the region
    a_r6_idx_bound: assert property (@(posedge clk) disable iff (rst)
        idx_q < FULL_LEN);
    // R8: reads only target a valid track and stay below its length
    a_r8_read_valid: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> (tbl_valid && idx_q < tbl_len));
    // R10: never a read and a write in the same cycle
    a_r10_we_re_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));
    // R2: memory accesses stay inside the shared memory
    a_r2_addr_range: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> mem_addr < ADDR_W'(N_TRACKS * REGION_LEN));
    // R3: a recording starts only from a single selected track
    a_r3_single_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !sel_single) |=> !rec_active);
endmodule

// File: tb/loop_sequencer_test.sv
module loop_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT  = 8;
    localparam int LEN = 5;
    localparam int LW  = 8;
    localparam int AW  = $clog2(NT * LEN);
    localparam int AWF = $clog2(8 * 480000);

    logic clk = 1'b0;
    logic rst;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NT-1:0] sel;
    logic          tgl, cnc, ply, tck;
    logic [15:0]   pcm;
    logic [AW-1:0] addr;
    logic          we, re, pv, ra;
    logic [15:0]   wdata;
    logic [2:0]    tidx;
    logic [LW-1:0] led;

    loop_sequencer #(.N_TRACKS(NT), .SAMPLE_W(16), .REGION_LEN(LEN), .LED_W(LW)) uut (
        .clk(clk), .rst(rst), .trk_sel(sel), .rec_pulse(tgl), .cancel_pulse(cnc),
        .play_en(ply), .tick(tck), .pcm_in(pcm), .mem_addr(addr), .mem_we(we),
        .mem_wdata(wdata), .mem_re(re), .trk_idx(tidx), .play_valid(pv),
        .rec_active(ra), .led(led)
    );

    logic [7:0]     f_sel;
    logic           f_tgl, f_tck;
    logic [AWF-1:0] f_addr;
    logic           f_we, f_re, f_pv, f_ra;
    logic [15:0]    f_wdata;
    logic [2:0]     f_tidx;
    logic [15:0]    f_led;

    loop_sequencer uut_full (
        .clk(clk), .rst(rst), .trk_sel(f_sel), .rec_pulse(f_tgl), .cancel_pulse(1'b0),
        .play_en(1'b0), .tick(f_tck), .pcm_in(16'h1234), .mem_addr(f_addr), .mem_we(f_we),
        .mem_wdata(f_wdata), .mem_re(f_re), .trk_idx(f_tidx), .play_valid(f_pv),
        .rec_active(f_ra), .led(f_led)
    );

    int n_vec = 0;
    int n_bad = 0;

    // reference state, derived from the requirements
    int m_st = 0;          // 0 idle, 1 recording, 2 playing
    int m_trk = 0;
    int m_idx = 0;
    bit m_vld [NT];
    int m_len [NT];

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pos_of(input logic [NT-1:0] s);
        int p = 0;
        for (int i = 0; i < NT; i++) if (s[i]) p = i;
        return p;
    endfunction

    task automatic step(input bit tk, input bit tg, input bit cn, input bit pl,
                        input logic [NT-1:0] s, input logic [15:0] d);
        bit one, e_we, e_re;
        int e_led;
        @(negedge clk);
        tck = tk; tgl = tg; cnc = cn; ply = pl; sel = s; pcm = d;
        #1;
        one   = ($countones(s) == 1);
        e_we  = (m_st == 1) && tk && !cn && !tg;
        e_re  = (m_st == 2) && pl && tk;
        e_led = (m_st == 2) ? 255 : (m_st == 1) ? 15 : 0;
        chk("R4 rec_active", int'(ra), int'(m_st == 1));
        chk("R9 led", int'(led), e_led);
        chk("R10 mem_we", int'(we), int'(e_we));
        chk("R8 mem_re", int'(re), int'(e_re));
        chk("R8 play_valid", int'(pv), int'(e_re));
        if (e_we) begin
            chk("R2 write addr", int'(addr), m_trk * LEN + m_idx);
            chk("R4 wdata", int'(wdata), int'(d));
        end
        if (e_re) chk("R2 read addr", int'(addr), m_trk * LEN + m_idx);
        if (m_st != 0) chk("R2 trk_idx", int'(tidx), m_trk);
        case (m_st)
            0: begin
                if (tg && one) begin m_st = 1; m_trk = pos_of(s); m_idx = 0; end
                else if (pl && one && m_vld[pos_of(s)]) begin
                    m_st = 2; m_trk = pos_of(s); m_idx = 0;
                end
            end
            1: begin
                if (cn) m_st = 0;
                else if (tg) begin
                    m_st = 0; m_vld[m_trk] = (m_idx != 0); m_len[m_trk] = m_idx;
                end else if (tk) begin
                    if (m_idx == LEN - 1) begin
                        m_st = 0; m_vld[m_trk] = 1'b1; m_len[m_trk] = LEN;
                    end else m_idx++;
                end
            end
            default: begin
                if (!pl) m_st = 0;
                else if (tk) m_idx = (m_idx + 1 == m_len[m_trk]) ? 0 : m_idx + 1;
            end
        endcase
    endtask

    task automatic record(input int t, input int k);
        step(0, 1, 0, 0, NT'(1 << t), 0);
        for (int i = 0; i < k; i++) begin
            step(1, 0, 0, 0, NT'(1 << t), 16'(t * 100 + i));
            if (i % 2 == 0) step(0, 0, 0, 0, 0, 0);
        end
        if (k < LEN) step(0, 1, 0, 0, 0, 0);
    endtask

    task automatic play(input int t, input int n);
        for (int i = 0; i < n; i++) step(i % 3 != 2, 0, 0, 1, NT'(1 << t), 0);
        step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NT; i++) begin m_vld[i] = 0; m_len[i] = 0; end
        rst = 1'b1; sel = '0; tgl = 0; cnc = 0; ply = 0; tck = 0; pcm = '0;
        f_sel = '0; f_tgl = 0; f_tck = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: idle after reset, nothing is readable
        #1;
        chk("R1 reset led", int'(led), 0);
        chk("R1 reset rec_active", int'(ra), 0);
        for (int t = 0; t < NT; t++) play(t, 3);

        // R3: sweep every select pattern against the record pulse
        for (int s = 0; s < 256; s++) begin
            step(0, 1, 0, 0, NT'(s), 0);
            step(0, 0, 1, 0, 0, 0);
        end

        // R4 R5 R6: record each track with a different length (0 .. LEN)
        for (int t = 0; t < NT; t++) record(t, t % (LEN + 1));
        // R8: loop each track several times
        for (int t = 0; t < NT; t++) play(t, 14);

        // R7: re-record track 3 partly, then cancel; old length must hold
        step(0, 1, 0, 0, 8'h08, 0);
        step(1, 0, 0, 0, 8'h08, 16'hAAAA);
        step(1, 0, 0, 0, 8'h08, 16'hBBBB);
        step(0, 0, 1, 0, 8'h08, 0);
        play(3, 12);

        // R10: cancel, pulse and tick together: cancel wins, nothing written
        step(0, 1, 0, 0, 8'h04, 0);
        step(1, 1, 1, 0, 8'h04, 16'h5555);
        play(2, 10);
        // R10: pulse with tick commits without writing
        step(0, 1, 0, 0, 8'h02, 0);
        step(1, 0, 0, 0, 8'h02, 16'h0101);
        step(1, 1, 0, 0, 8'h02, 16'h0202);
        play(1, 8);
        // R10: record pulse during playback is ignored
        step(0, 0, 0, 1, 8'h02, 0);
        step(1, 1, 0, 1, 8'h02, 0);
        step(1, 0, 0, 1, 8'h10, 0);
        step(0, 0, 0, 0, 0, 0);

        // R5: overwrite track 5 with a shorter take
        record(5, 2);
        play(5, 7);
        // R5: zero-length commit empties track 4
        record(4, 0);
        play(4, 4);

        // R2: full-size configuration, track 3 index 5824
        @(negedge clk) begin f_sel = 8'h08; f_tgl = 1; end
        @(negedge clk) begin f_tgl = 0; f_tck = 1; end
        repeat (5824) @(negedge clk);
        #1;
        chk("R2 full addr", int'(f_addr), 32'h160FC0);
        chk("R2 full we", int'(f_we), 1);
        chk("R2 full trk_idx", int'(f_tidx), 3);
        chk("R9 full led", int'(f_led), 16'h00FF);
        f_tck = 0;

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule